// File: doc/BRIEF.md
# Dual-Reload PWM Timer

This block is a down-counting timer that produces a pulse-width-modulated waveform from two reload values. The counter is reloaded from the two values in turn. The value that is loaded while the output is high sets the high time. The other value sets the low time. Each time the counter passes below zero, three things happen:

- the counter reloads from the other value;
- the output may toggle;
- one of two pending flags is set.

Each of those flags has its own interrupt enable. Software can therefore take an interrupt on the rising edge of the waveform, on the falling edge, or on both.

Software reaches the block through a small write port. The port has three writable locations: the two reload values and a control word. A fourth address holds no storage; a write to it clears pending flags. The counter steps down once on each cycle in which the `tick` input is high, so an outside prescaler sets the time base. The `run` input starts and stops the waveform. The pending flags are brought out as ports together with the combined interrupt request.

Top module: `dual_reload_pwm`

## Requirements
- R1: After reset `pwm_out`, `irq`, `pend_a` and `pend_b` are all 0, and the block stays idle while `run` is low.
- R2: On the first clock edge at which `run` is seen high after being low, the counter loads reload value A and `pwm_out` goes high. With `tick` held high, the output then stays high for A+1 cycles.
- R3: The counter steps down only in cycles where `tick` is 1. When `tick` is 0, the counter and the output keep their state.
- R4: An underflow happens when the counter is 0 on a tick. It reloads the counter from the value that was not loaded last, so the loads alternate B, A, B, and so on. With `tick` held high, the low time is B+1 cycles.
- R5: When toggle enable (control bit 2) is 1, every underflow inverts `pwm_out`. When it is 0, underflows still reload the counter and set flags, but `pwm_out` holds its level.
- R6: An underflow that loads value A sets `pend_a`. An underflow that loads value B sets `pend_b`. Successive underflows therefore set the two flags alternately.
- R7: A pending flag stays set until a write to address 3: data bit 0 clears `pend_a` and data bit 1 clears `pend_b`. A bit written as 0 leaves its flag unchanged.
- R8: `irq` is high exactly when (`pend_a` and enable A) or (`pend_b` and enable B). Enable A is control bit 0 and enable B is control bit 1. Both enables may be set together.
- R9: While `run` is low, `pwm_out` is 0, the counter does not underflow, and the pending flags hold their values.
- R10: Writes to address 0 set reload value A and writes to address 1 set reload value B. A new value takes effect at the next reload from that register, without disturbing the count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable; the counter steps once per high cycle |
| run | input | 1 | High to run the waveform; a rise restarts it from value A |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 reload A, 1 reload B, 2 control, 3 flag clear |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | Waveform output |
| irq | output | 1 | Interrupt request |
| pend_a | output | 1 | Pending flag for underflows that load value A |
| pend_b | output | 1 | Pending flag for underflows that load value B |

## Verification
Every result appears one clock edge after the cause is sampled:
- the output rises at the edge that sees `run` high;
- an underflow changes the output and sets its flag at the edge that follows the cycle in which the counter reads 0;
- a write or flag clear is visible after the edge on which the strobe is high.

The bench drives all inputs on falling edges and samples on falling edges. It counts high and low widths in whole falling-edge samples, so an expected width of A+1 or B+1 can be compared without any sub-cycle ambiguity. Flag and `irq` checks are made at the first falling edge after the output changes level, or after the write that is under test. At those points the state has settled and the next underflow is still many cycles away.

// File: rtl/dual_reload_pwm.sv
module dual_reload_pwm #(
  parameter int W  = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic          pwm_out,
  output logic          irq,
  output logic          pend_a,
  output logic          pend_b
);

  localparam logic [AW-1:0] A_RELA = AW'(0);
  localparam logic [AW-1:0] A_RELB = AW'(1);
  localparam logic [AW-1:0] A_CTRL = AW'(2);
  localparam logic [AW-1:0] A_CLR  = AW'(3);

  logic [W-1:0] rel_a, rel_b, cnt;
  logic         active, load_b_next;
  logic         en_a, en_b, tog_en;

  wire start   = run && !active;
  wire uflow   = run && active && tick && (cnt == '0);
  wire clr_wr  = wr_en && (wr_addr == A_CLR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rel_a <= '0;
      rel_b <= '0;
      {tog_en, en_b, en_a} <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_RELA) rel_a <= wr_data;
      if (wr_addr == A_RELB) rel_b <= wr_data;
      if (wr_addr == A_CTRL) {tog_en, en_b, en_a} <= wr_data[2:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active      <= 1'b0;
      cnt         <= '0;
      load_b_next <= 1'b0;
      pwm_out     <= 1'b0;
    end else begin
      active <= run;
      if (!run) begin
        pwm_out <= 1'b0;
      end else if (start) begin
        cnt         <= rel_a;
        load_b_next <= 1'b1;
        pwm_out     <= 1'b1;
      end else if (uflow) begin
        cnt         <= load_b_next ? rel_b : rel_a;
        load_b_next <= !load_b_next;
        if (tog_en) pwm_out <= !pwm_out;
      end else if (tick) begin
        cnt <= cnt - 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_a <= 1'b0;
      pend_b <= 1'b0;
    end else begin
      if (uflow && !load_b_next)      pend_a <= 1'b1;
      else if (clr_wr && wr_data[0])  pend_a <= 1'b0;
      if (uflow && load_b_next)       pend_b <= 1'b1;
      else if (clr_wr && wr_data[1])  pend_b <= 1'b0;
    end

  assign irq = (pend_a && en_a) || (pend_b && en_b);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && run && !tick) |=> (cnt == $past(cnt)));

  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> (cnt == ($past(load_b_next) ? $past(rel_b) : $past(rel_a))));

  a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && tog_en) |=> (pwm_out != $past(pwm_out)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !tog_en) |=> $stable(pwm_out));

  a_r6_flag_b: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && load_b_next) |=> pend_b);

  a_r6_flag_a: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !load_b_next) |=> pend_a);

  a_r8_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_a || pend_b));

  a_r9_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pwm_out);

endmodule

// File: tb/dual_reload_pwm_tb.sv
module dual_reload_pwm_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic run = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic pwm_out, irq, pend_a, pend_b;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = !clk;

  dual_reload_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .irq(irq), .pend_a(pend_a), .pend_b(pend_b)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (pwm_out == lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic start_run();
    run = 1'b1;
    @(negedge clk);
  endtask

  task automatic stop_run();
    run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int hi, lo;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pwm", pwm_out, 0);
    check("R1 irq", irq, 0);
    check("R1 pend", {pend_a, pend_b}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 idle pwm", pwm_out, 0);
    check("R1 idle pend", {pend_a, pend_b}, 0);

    wr(2'd2, 16'h4);
    // R2 R4 R5 R6 sweep of high/low widths
    for (int a = 0; a < 5; a++) begin
      for (int b = 0; b < 5; b++) begin
        wr(2'd0, 16'(a));
        wr(2'd1, 16'(b));
        wr(2'd3, 16'h3);
        start_run();
        count_level(1'b1, hi);
        check("R2 high width", hi, a + 1);
        check("R6 first flags", {pend_a, pend_b}, 1);
        count_level(1'b0, lo);
        check("R4 low width", lo, b + 1);
        check("R6 both flags", {pend_a, pend_b}, 3);
        check("R8 masked", irq, 0);
        stop_run();
      end
    end

    // R3 tick gating
    wr(2'd0, 16'd10);
    wr(2'd1, 16'd3);
    wr(2'd3, 16'h3);
    tick = 1'b0;
    start_run();
    repeat (30) @(negedge clk);
    check("R3 held high", pwm_out, 1);
    check("R3 no underflow", {pend_a, pend_b}, 0);
    tick = 1'b1;
    count_level(1'b1, hi);
    check("R3 high after resume", hi, 11);
    stop_run();

    // R7 R8 flag clear and interrupt enables
    wr(2'd0, 16'd40);
    wr(2'd1, 16'd40);
    wr(2'd3, 16'h3);
    start_run();
    count_level(1'b1, hi);
    check("R6 pend_b only", {pend_a, pend_b}, 1);
    check("R8 irq off", irq, 0);
    wr(2'd2, 16'h6);
    check("R8 irq enb", irq, 1);
    wr(2'd3, 16'h1);
    check("R7 zero bit no clear", pend_b, 1);
    wr(2'd3, 16'h2);
    check("R7 pend_b cleared", pend_b, 0);
    check("R8 irq after clear", irq, 0);
    count_level(1'b0, lo);
    check("R6 pend_a set", {pend_a, pend_b}, 2);
    check("R8 ena off", irq, 0);
    wr(2'd2, 16'h7);
    check("R8 irq ena", irq, 1);
    repeat (20) @(negedge clk);
    check("R7 flag sticky", pend_a, 1);
    wr(2'd3, 16'h1);
    check("R7 pend_a cleared", {pend_a, pend_b}, 0);
    check("R8 irq none", irq, 0);
    count_level(1'b1, hi);
    check("R8 both edges irq", irq, 1);
    check("R6 pend_b again", {pend_a, pend_b}, 1);
    stop_run();

    // R9 stopped state
    check("R9 pwm low", pwm_out, 0);
    wr(2'd3, 16'h3);
    repeat (60) @(negedge clk);
    check("R9 pwm stays low", pwm_out, 0);
    check("R9 no flags", {pend_a, pend_b}, 0);

    // R10 reload update mid-run
    wr(2'd2, 16'h4);
    wr(2'd0, 16'd5);
    wr(2'd1, 16'd5);
    start_run();
    count_level(1'b1, hi);
    check("R10 first high", hi, 6);
    wr(2'd0, 16'd8);
    count_level(1'b0, lo);
    check("R10 low unaffected", lo, 5);
    count_level(1'b1, hi);
    check("R10 new high", hi, 9);
    stop_run();

    // R5 toggle disabled
    wr(2'd2, 16'h0);
    wr(2'd0, 16'd2);
    wr(2'd1, 16'd2);
    wr(2'd3, 16'h3);
    start_run();
    repeat (20) @(negedge clk);
    check("R5 no toggle", pwm_out, 1);
    check("R5 flags still set", {pend_a, pend_b}, 3);
    stop_run();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule